// File: doc/BRIEF.md
# Key-Value GET Lookup Engine

This block answers key-value read requests in hardware, with no software involvement. A request enters one key byte per beat, with its operation code and a tag. While the bytes arrive, the engine folds them into a 64-bit identifier. The low bits of that identifier select a bucket of four slots in an on-chip table. All four slots are compared against the identifier in one cycle.

A read that finds its key leaves on the hit port. It carries a handle (pointer and value length) to where the value lives elsewhere, and the slot's last-access time is set to the current value of a free-running counter. A read that misses, any other operation, and any key with an illegal length all leave on the software port, together with the identifier and the key length.

Software fills and prunes the table through a one-cycle maintenance port. The engine holds one request at a time, so responses always leave in request order.

Top module: `kvl_get_engine`

## Requirements
- R1: A key has 1 to 255 bytes, counted over beats with `req_keep` high. A request whose count is 0 or above 255 gets a software response of kind 3 (reject), whatever its operation code. `sw_klen` reports the count, saturating at 256.
- R2: The identifier is 64-bit FNV-1a over the key bytes in arrival order (start value cbf29ce484222325 hex, multiplier 100000001b3 hex, xor before multiply). The bucket index is its low log2(BUCKETS) bits. Every software response carries it on `sw_id`.
- R3: A read (op code 0) with a legal key compares all four slots of its bucket. If a slot is valid and holds the same identifier, the engine raises `hit_valid` with the request tag and that slot's pointer and value length.
- R4: On a hit, the slot's timestamp becomes the current time count. This is visible through which slot a later insert displaces.
- R5: A read with a legal key and no matching slot gets a software response of kind 1 (miss), carrying the tag, the op code and the identifier.
- R6: Op codes 1, 2 and 3 with a legal key get a software response of kind 2 (forward), carrying the op code, tag, identifier and key length unchanged. The table is not touched.
- R7: An insert (`mnt_del` low) whose identifier already sits in the bucket overwrites that slot. Otherwise it takes the lowest-numbered invalid slot. If all four slots are valid, it replaces the slot with the oldest timestamp (the lowest-numbered one on a tie). The written slot's timestamp is the current time.
- R8: A delete (`mnt_del` high) invalidates the slot holding that identifier and leaves the other slots of the bucket intact.
- R9: The response is valid two clock edges after the edge that accepts the last key byte. `req_ready` stays low from that edge until the response handshakes. A response under backpressure holds its contents stable.
- R10: `mnt_ready` is low during the lookup cycle (the cycle after the last key byte is accepted). `hit_valid` and `sw_valid` are never high together.
- R11: After reset the table is empty, no response is valid, and both `req_ready` and `mnt_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Key beat valid |
| req_ready | output | 1 | Engine accepts a key beat |
| req_op | input | 2 | Op code: 0 read, 1 store, 2 remove, 3 other (taken on last beat) |
| req_tag | input | TAG_W | Request tag (taken on last beat) |
| req_byte | input | 8 | Key byte |
| req_keep | input | 1 | Beat carries a key byte |
| req_last | input | 1 | Final beat of the request |
| hit_valid | output | 1 | Hit response valid |
| hit_ready | input | 1 | Hit response taken |
| hit_tag | output | TAG_W | Tag of the answered request |
| hit_ptr | output | 32 | Value pointer |
| hit_vlen | output | 20 | Value length |
| sw_valid | output | 1 | Software response valid |
| sw_ready | input | 1 | Software response taken |
| sw_kind | output | 2 | 1 miss, 2 forward, 3 reject |
| sw_op | output | 2 | Op code of the request |
| sw_tag | output | TAG_W | Tag of the request |
| sw_id | output | 64 | Key identifier |
| sw_klen | output | 9 | Key byte count, saturating at 256 |
| mnt_valid | input | 1 | Maintenance command valid |
| mnt_ready | output | 1 | Maintenance command accepted |
| mnt_del | input | 1 | 1 delete, 0 insert |
| mnt_id | input | 64 | Identifier to insert or delete |
| mnt_ptr | input | 32 | Pointer for insert |
| mnt_vlen | input | 20 | Value length for insert |

## Verification
The assertions assume that `req_op` and `req_tag` stay constant across the beats of one request. They also assume that the reset is held low from time zero until a few clock edges have passed. The bench drives every beat of a request from one task call with a fixed op code and tag. It raises reset only after several edges. Maintenance commands change only on falling edges and are held until an accepting rising edge.

// File: rtl/kvl_pkg.sv
package kvl_pkg;
    localparam int ID_W    = 64;
    localparam int PTR_W   = 32;
    localparam int VLEN_W  = 20;
    localparam int TS_W    = 32;
    localparam int KLEN_W  = 9;
    localparam int MAX_KEY = 255;
    localparam logic [ID_W-1:0] FOLD_SEED = 64'hcbf29ce484222325;
    localparam logic [ID_W-1:0] FOLD_MUL  = 64'h00000100000001b3;

    typedef enum logic [1:0] {
        OP_GET   = 2'd0,
        OP_SET   = 2'd1,
        OP_DEL   = 2'd2,
        OP_OTHER = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SW_NONE   = 2'd0,
        SW_MISS   = 2'd1,
        SW_FWD    = 2'd2,
        SW_REJECT = 2'd3
    } swkind_e;

    typedef enum logic [1:0] {
        ST_RECV = 2'd0,
        ST_LOOK = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   id;
        logic [PTR_W-1:0]  ptr;
        logic [VLEN_W-1:0] vlen;
        logic [TS_W-1:0]   ts;
    } slot_t;
endpackage

// File: rtl/kvl_keyfold.sv
module kvl_keyfold
    import kvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              clr,
    output logic [ID_W-1:0]   id,
    output logic [KLEN_W-1:0] klen
);
    typedef struct packed {
        logic [ID_W-1:0]   h;
        logic [KLEN_W-1:0] n;
    } fold_t;

    fold_t fold_d, fold_q;

    always_comb begin
        fold_d = fold_q;
        if (clr) begin
            fold_d.h = FOLD_SEED;
            fold_d.n = '0;
        end else if (byte_vld) begin
            fold_d.h = (fold_q.h ^ {{(ID_W-8){1'b0}}, byte_in}) * FOLD_MUL;
            if (fold_q.n <= KLEN_W'(MAX_KEY)) begin
                fold_d.n = fold_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fold_q.h <= FOLD_SEED;
            fold_q.n <= '0;
        end else begin
            fold_q <= fold_d;
        end
    end

    assign id   = fold_q.h;
    assign klen = fold_q.n;
endmodule

// File: rtl/kvl_table.sv
module kvl_table
    import kvl_pkg::*;
#(
    parameter int BUCKETS = 16,
    parameter int WAYS    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(BUCKETS)-1:0] rd_idx,
    output slot_t [WAYS-1:0]           rd_slots,
    input  logic                       wr_en,
    input  logic [$clog2(BUCKETS)-1:0] wr_idx,
    input  logic [$clog2(WAYS)-1:0]    wr_way,
    input  slot_t                      wr_slot
);
    slot_t [WAYS-1:0] mem_q [BUCKETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BUCKETS; b++) begin
                for (int w = 0; w < WAYS; w++) begin
                    mem_q[b][w] <= '0;
                end
            end
        end else if (wr_en) begin
            mem_q[wr_idx][wr_way] <= wr_slot;
        end
    end

    assign rd_slots = mem_q[rd_idx];
endmodule

// File: rtl/kvl_match.sv
module kvl_match
    import kvl_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][ID_W-1:0]  ids,
    input  logic [WAYS-1:0][TS_W-1:0]  ts,
    input  logic [ID_W-1:0]            key_id,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       has_free,
    output logic [WAY_W-1:0]           free_way,
    output logic [WAY_W-1:0]           old_way
);
    logic [WAYS-1:0] eq;
    logic [WAYS-1:0] empty;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w]    = vld[w] && (ids[w] == key_id);
        assign empty[w] = !vld[w];
    end

    assign hit      = |eq;
    assign has_free = |empty;

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                hit_way = WAY_W'(w);
            end
            if (empty[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        logic [TS_W-1:0] best;
        best    = ts[0];
        old_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (ts[w] < best) begin
                best    = ts[w];
                old_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/kvl_get_engine.sv
module kvl_get_engine
    import kvl_pkg::*;
#(
    parameter int BUCKETS = 16,
    parameter int WAYS    = 4,
    parameter int TAG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [7:0]        req_byte,
    input  logic              req_keep,
    input  logic              req_last,
    output logic              hit_valid,
    input  logic              hit_ready,
    output logic [TAG_W-1:0]  hit_tag,
    output logic [PTR_W-1:0]  hit_ptr,
    output logic [VLEN_W-1:0] hit_vlen,
    output logic              sw_valid,
    input  logic              sw_ready,
    output logic [1:0]        sw_kind,
    output logic [1:0]        sw_op,
    output logic [TAG_W-1:0]  sw_tag,
    output logic [ID_W-1:0]   sw_id,
    output logic [KLEN_W-1:0] sw_klen,
    input  logic              mnt_valid,
    output logic              mnt_ready,
    input  logic              mnt_del,
    input  logic [ID_W-1:0]   mnt_id,
    input  logic [PTR_W-1:0]  mnt_ptr,
    input  logic [VLEN_W-1:0] mnt_vlen
);
    localparam int IDX_W = $clog2(BUCKETS);
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        state_e            st;
        logic [1:0]        op;
        logic [TAG_W-1:0]  tag;
        logic [TS_W-1:0]   now;
        logic              rsp_hit;
        logic [1:0]        rsp_kind;
        logic [PTR_W-1:0]  rsp_ptr;
        logic [VLEN_W-1:0] rsp_vlen;
        logic [ID_W-1:0]   rsp_id;
        logic [KLEN_W-1:0] rsp_klen;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              byte_vld;
    logic              fold_clr;
    logic [ID_W-1:0]   fold_id;
    logic [KLEN_W-1:0] fold_klen;

    logic [ID_W-1:0]   key_sel;
    logic [IDX_W-1:0]  rd_idx;
    slot_t [WAYS-1:0]  rd_slots;
    logic              wr_en;
    logic [WAY_W-1:0]  wr_way;
    slot_t             wr_slot;

    logic [WAYS-1:0]           way_vld;
    logic [WAYS-1:0][ID_W-1:0] way_id;
    logic [WAYS-1:0][TS_W-1:0] way_ts;
    logic                      m_hit;
    logic [WAY_W-1:0]          m_hit_way;
    logic                      m_has_free;
    logic [WAY_W-1:0]          m_free_way;
    logic [WAY_W-1:0]          m_old_way;

    logic in_look;
    logic mnt_go;

    assign in_look   = (ctl_q.st == ST_LOOK);
    assign req_ready = (ctl_q.st == ST_RECV);
    assign mnt_ready = !in_look;
    assign mnt_go    = mnt_valid && mnt_ready;
    assign byte_vld  = req_valid && req_ready && req_keep;
    assign key_sel   = in_look ? fold_id : mnt_id;
    assign rd_idx    = key_sel[IDX_W-1:0];

    kvl_keyfold u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_in  (req_byte),
        .clr      (fold_clr),
        .id       (fold_id),
        .klen     (fold_klen)
    );

    kvl_table #(.BUCKETS(BUCKETS), .WAYS(WAYS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_slots (rd_slots),
        .wr_en    (wr_en),
        .wr_idx   (rd_idx),
        .wr_way   (wr_way),
        .wr_slot  (wr_slot)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_split
        assign way_vld[w] = rd_slots[w].vld;
        assign way_id[w]  = rd_slots[w].id;
        assign way_ts[w]  = rd_slots[w].ts;
    end

    kvl_match #(.WAYS(WAYS)) u_match (
        .vld      (way_vld),
        .ids      (way_id),
        .ts       (way_ts),
        .key_id   (key_sel),
        .hit      (m_hit),
        .hit_way  (m_hit_way),
        .has_free (m_has_free),
        .free_way (m_free_way),
        .old_way  (m_old_way)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.now = ctl_q.now + 1'b1;
        fold_clr  = 1'b0;
        wr_en     = 1'b0;
        wr_way    = '0;
        wr_slot   = '0;

        unique case (ctl_q.st)
            ST_RECV: begin
                if (req_valid && req_last) begin
                    ctl_d.op  = req_op;
                    ctl_d.tag = req_tag;
                    ctl_d.st  = ST_LOOK;
                end
            end
            ST_LOOK: begin
                fold_clr       = 1'b1;
                ctl_d.st       = ST_RESP;
                ctl_d.rsp_id   = fold_id;
                ctl_d.rsp_klen = fold_klen;
                ctl_d.rsp_hit  = 1'b0;
                ctl_d.rsp_ptr  = '0;
                ctl_d.rsp_vlen = '0;
                if (fold_klen == '0 || fold_klen > KLEN_W'(MAX_KEY)) begin
                    ctl_d.rsp_kind = SW_REJECT;
                end else if (ctl_q.op != OP_GET) begin
                    ctl_d.rsp_kind = SW_FWD;
                end else if (m_hit) begin
                    ctl_d.rsp_hit  = 1'b1;
                    ctl_d.rsp_kind = SW_NONE;
                    ctl_d.rsp_ptr  = rd_slots[m_hit_way].ptr;
                    ctl_d.rsp_vlen = rd_slots[m_hit_way].vlen;
                    wr_en          = 1'b1;
                    wr_way         = m_hit_way;
                    wr_slot        = rd_slots[m_hit_way];
                    wr_slot.ts     = ctl_q.now;
                end else begin
                    ctl_d.rsp_kind = SW_MISS;
                end
            end
            ST_RESP: begin
                if ((ctl_q.rsp_hit && hit_ready) || (!ctl_q.rsp_hit && sw_ready)) begin
                    ctl_d.st = ST_RECV;
                end
            end
            default: ctl_d.st = ST_RECV;
        endcase

        if (mnt_go) begin
            if (mnt_del) begin
                wr_en   = m_hit;
                wr_way  = m_hit_way;
                wr_slot = '0;
            end else begin
                wr_en        = 1'b1;
                wr_way       = m_hit ? m_hit_way : (m_has_free ? m_free_way : m_old_way);
                wr_slot.vld  = 1'b1;
                wr_slot.id   = mnt_id;
                wr_slot.ptr  = mnt_ptr;
                wr_slot.vlen = mnt_vlen;
                wr_slot.ts   = ctl_q.now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_RECV;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hit_valid = (ctl_q.st == ST_RESP) && ctl_q.rsp_hit;
    assign hit_tag   = ctl_q.tag;
    assign hit_ptr   = ctl_q.rsp_ptr;
    assign hit_vlen  = ctl_q.rsp_vlen;
    assign sw_valid  = (ctl_q.st == ST_RESP) && !ctl_q.rsp_hit;
    assign sw_kind   = ctl_q.rsp_kind;
    assign sw_op     = ctl_q.op;
    assign sw_tag    = ctl_q.tag;
    assign sw_id     = ctl_q.rsp_id;
    assign sw_klen   = ctl_q.rsp_klen;
endmodule

// File: rtl/kvl_get_engine_chk.sv
module kvl_get_engine_chk
    import kvl_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_last,
    input logic              hit_valid,
    input logic              hit_ready,
    input logic [TAG_W-1:0]  hit_tag,
    input logic [PTR_W-1:0]  hit_ptr,
    input logic [VLEN_W-1:0] hit_vlen,
    input logic              sw_valid,
    input logic              sw_ready,
    input logic [1:0]        sw_kind,
    input logic [1:0]        sw_op,
    input logic [TAG_W-1:0]  sw_tag,
    input logic [ID_W-1:0]   sw_id,
    input logic [KLEN_W-1:0] sw_klen,
    input logic              mnt_ready
);
    AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_valid && sw_valid)); // R10

    AST_LOOK_BLOCKS_MNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_last) |=> !mnt_ready); // R10

    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_last) |=> ##1 (hit_valid || sw_valid)); // R9

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid || sw_valid) |-> !req_ready); // R9

    AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_ready) |=>
            (hit_valid && $stable(hit_tag) && $stable(hit_ptr) && $stable(hit_vlen))); // R9

    AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && !sw_ready) |=>
            (sw_valid && $stable(sw_kind) && $stable(sw_tag) && $stable(sw_id) && $stable(sw_op))); // R9

    AST_REJECT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_kind == 2'd3) |-> (sw_klen == '0 || sw_klen > KLEN_W'(MAX_KEY))); // R1

    AST_FWD_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_kind == 2'd2) |-> (sw_op != 2'd0)); // R6

    AST_MISS_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_kind == 2'd1) |-> (sw_op == 2'd0 && sw_klen != '0 && sw_klen <= KLEN_W'(MAX_KEY))); // R5

    AST_SW_KIND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |-> (sw_kind != 2'd0)); // R5
endmodule

bind kvl_get_engine kvl_get_engine_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_last  (req_last),
    .hit_valid (hit_valid),
    .hit_ready (hit_ready),
    .hit_tag   (hit_tag),
    .hit_ptr   (hit_ptr),
    .hit_vlen  (hit_vlen),
    .sw_valid  (sw_valid),
    .sw_ready  (sw_ready),
    .sw_kind   (sw_kind),
    .sw_op     (sw_op),
    .sw_tag    (sw_tag),
    .sw_id     (sw_id),
    .sw_klen   (sw_klen),
    .mnt_ready (mnt_ready)
);

// File: tb/tb_kvl_get_engine.sv
module tb_kvl_get_engine;
    localparam int BK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_tag = 8'd0;
    logic [7:0]  req_byte = 8'd0;
    logic        req_keep = 1'b0;
    logic        req_last = 1'b0;
    logic        hit_valid;
    logic        hit_ready = 1'b1;
    logic [7:0]  hit_tag;
    logic [31:0] hit_ptr;
    logic [19:0] hit_vlen;
    logic        sw_valid;
    logic        sw_ready = 1'b1;
    logic [1:0]  sw_kind;
    logic [1:0]  sw_op;
    logic [7:0]  sw_tag;
    logic [63:0] sw_id;
    logic [8:0]  sw_klen;
    logic        mnt_valid = 1'b0;
    logic        mnt_ready;
    logic        mnt_del = 1'b0;
    logic [63:0] mnt_id = 64'd0;
    logic [31:0] mnt_ptr = 32'd0;
    logic [19:0] mnt_vlen = 20'd0;

    always #2 clk = ~clk;

    kvl_get_engine #(.BUCKETS(BK), .WAYS(4), .TAG_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_tag(req_tag),
        .req_byte(req_byte), .req_keep(req_keep), .req_last(req_last),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_tag(hit_tag),
        .hit_ptr(hit_ptr), .hit_vlen(hit_vlen),
        .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_kind(sw_kind), .sw_op(sw_op),
        .sw_tag(sw_tag), .sw_id(sw_id), .sw_klen(sw_klen),
        .mnt_valid(mnt_valid), .mnt_ready(mnt_ready), .mnt_del(mnt_del),
        .mnt_id(mnt_id), .mnt_ptr(mnt_ptr), .mnt_vlen(mnt_vlen)
    );

    int n_chk = 0;
    int n_err = 0;

    logic        r_hit;
    logic [1:0]  r_kind;
    logic [7:0]  r_tag;
    logic [31:0] r_ptr;
    logic [19:0] r_vlen;
    logic [63:0] r_id;
    logic [8:0]  r_klen;
    logic [1:0]  r_op;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  seed;
        logic [8:0]  len;
        logic [1:0]  kind;
        logic        hit;
        logic [31:0] ptr;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{2'd0, 8'd10, 9'd5,   2'd0, 1'b1, 32'h0000_1000},
        '{2'd0, 8'd11, 9'd200, 2'd0, 1'b1, 32'h0000_2000},
        '{2'd0, 8'd12, 9'd255, 2'd0, 1'b1, 32'h0000_3000},
        '{2'd0, 8'd13, 9'd1,   2'd0, 1'b1, 32'h0000_4000},
        '{2'd1, 8'd10, 9'd5,   2'd2, 1'b0, 32'h0},
        '{2'd2, 8'd11, 9'd200, 2'd2, 1'b0, 32'h0},
        '{2'd3, 8'd12, 9'd255, 2'd2, 1'b0, 32'h0},
        '{2'd0, 8'd14, 9'd5,   2'd1, 1'b0, 32'h0},
        '{2'd0, 8'd10, 9'd6,   2'd1, 1'b0, 32'h0},
        '{2'd1, 8'd0,  9'd0,   2'd3, 1'b0, 32'h0},
        '{2'd0, 8'd13, 9'd256, 2'd3, 1'b0, 32'h0}
    };

    function automatic logic [7:0] key_byte(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic [63:0] fnv(input int seed, input int len);
        logic [63:0] h;
        h = 64'hcbf29ce484222325;
        for (int i = 0; i < len; i++) begin
            h = (h ^ {56'd0, key_byte(seed, i)}) * 64'h00000100000001b3;
        end
        return h;
    endfunction

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic send_req(input logic [1:0] op, input logic [7:0] tag, input int seed, input int len);
        int beats;
        beats = (len == 0) ? 1 : len;
        for (int i = 0; i < beats; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_op    = op;
            req_tag   = tag;
            req_byte  = key_byte(seed, i);
            req_keep  = (len != 0);
            req_last  = (i == beats - 1);
            while (!req_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_last  = 1'b0;
    endtask

    task automatic get_resp();
        int t;
        t = 0;
        while (!(hit_valid || sw_valid) && t < 40) begin
            @(negedge clk);
            t++;
        end
        r_hit  = hit_valid;
        r_kind = sw_kind;
        r_tag  = hit_valid ? hit_tag : sw_tag;
        r_ptr  = hit_ptr;
        r_vlen = hit_vlen;
        r_id   = sw_id;
        r_klen = sw_klen;
        r_op   = sw_op;
        if (!(hit_valid || sw_valid)) begin
            n_chk++;
            n_err++;
            $display("FAIL R9 response timeout: got 0 expected 1");
        end else begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_hit(input string rq, input logic [7:0] tag, input logic [31:0] ptr, input logic [19:0] vl);
        get_resp();
        chk(rq, "hit_valid", {63'd0, r_hit}, 64'd1);
        chk(rq, "hit_tag", {56'd0, r_tag}, {56'd0, tag});
        if (r_hit) begin
            chk(rq, "hit_ptr", {32'd0, r_ptr}, {32'd0, ptr});
            chk(rq, "hit_vlen", {44'd0, r_vlen}, {44'd0, vl});
        end
    endtask

    task automatic expect_sw(input string rq, input logic [1:0] kind, input logic [7:0] tag,
                             input logic [1:0] op, input int seed, input int len);
        int kl;
        kl = (len > 256) ? 256 : len;
        get_resp();
        chk(rq, "sw path", {63'd0, r_hit}, 64'd0);
        chk(rq, "sw_kind", {62'd0, r_kind}, {62'd0, kind});
        chk(rq, "sw_tag", {56'd0, r_tag}, {56'd0, tag});
        chk(rq, "sw_op", {62'd0, r_op}, {62'd0, op});
        chk(rq, "sw_klen", {55'd0, r_klen}, 64'(kl));
        chk("R2", "sw_id", r_id, fnv(seed, len));
    endtask

    task automatic mnt(input logic del, input int seed, input int len, input logic [31:0] ptr, input logic [19:0] vl);
        @(negedge clk);
        mnt_valid = 1'b1;
        mnt_del   = del;
        mnt_id    = fnv(seed, len);
        mnt_ptr   = ptr;
        mnt_vlen  = vl;
        while (!mnt_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        mnt_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int cs [5];
        int nf;
        logic [63:0] h0;
        logic [63:0] hx;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", "hit_valid", {63'd0, hit_valid}, 64'd0);
        chk("R11", "sw_valid", {63'd0, sw_valid}, 64'd0);
        chk("R11", "req_ready", {63'd0, req_ready}, 64'd1);
        chk("R11", "mnt_ready", {63'd0, mnt_ready}, 64'd1);
        send_req(2'd0, 8'h01, 10, 5);
        expect_sw("R11", 2'd1, 8'h01, 2'd0, 10, 5);

        // R7 / R4 collision set: five keys sharing one bucket
        nf = 0;
        h0 = fnv(20, 4);
        for (int s = 20; s < 256; s++) begin
            hx = fnv(s, 4);
            if (nf < 5 && hx[3:0] == h0[3:0]) begin
                cs[nf] = s;
                nf++;
            end
        end
        chk("R7", "collision keys found", 64'(nf), 64'd5);
        if (nf == 5) begin
            for (int k = 0; k < 4; k++) mnt(1'b0, cs[k], 4, 32'h5000_0000 + 32'(k), 20'(k + 1));
            for (int k = 0; k < 4; k++) begin
                send_req(2'd0, 8'(8'h10 + k), cs[k], 4);
                expect_hit("R3", 8'(8'h10 + k), 32'h5000_0000 + 32'(k), 20'(k + 1));
            end
            send_req(2'd0, 8'h20, cs[0], 4);
            expect_hit("R4", 8'h20, 32'h5000_0000, 20'd1);
            mnt(1'b0, cs[4], 4, 32'h5000_0004, 20'd5);
            send_req(2'd0, 8'h21, cs[1], 4);
            expect_sw("R7", 2'd1, 8'h21, 2'd0, cs[1], 4);
            send_req(2'd0, 8'h22, cs[0], 4);
            expect_hit("R4", 8'h22, 32'h5000_0000, 20'd1);
            send_req(2'd0, 8'h23, cs[4], 4);
            expect_hit("R7", 8'h23, 32'h5000_0004, 20'd5);
            mnt(1'b0, cs[0], 4, 32'h6000_0000, 20'd9);
            send_req(2'd0, 8'h24, cs[0], 4);
            expect_hit("R7", 8'h24, 32'h6000_0000, 20'd9);
            send_req(2'd0, 8'h25, cs[3], 4);
            expect_hit("R7", 8'h25, 32'h5000_0003, 20'd4);
            mnt(1'b1, cs[2], 4, 32'd0, 20'd0);
            send_req(2'd0, 8'h26, cs[2], 4);
            expect_sw("R8", 2'd1, 8'h26, 2'd0, cs[2], 4);
            send_req(2'd0, 8'h27, cs[3], 4);
            expect_hit("R8", 8'h27, 32'h5000_0003, 20'd4);
            mnt(1'b0, cs[1], 4, 32'h7000_0001, 20'd7);
            send_req(2'd0, 8'h28, cs[1], 4);
            expect_hit("R7", 8'h28, 32'h7000_0001, 20'd7);
            send_req(2'd0, 8'h29, cs[4], 4);
            expect_hit("R7", 8'h29, 32'h5000_0004, 20'd5);
            send_req(2'd0, 8'h2a, cs[0], 4);
            expect_hit("R7", 8'h2a, 32'h6000_0000, 20'd9);
            mnt(1'b1, cs[0], 4, 32'd0, 20'd0);
            mnt(1'b1, cs[1], 4, 32'd0, 20'd0);
            mnt(1'b1, cs[3], 4, 32'd0, 20'd0);
            mnt(1'b1, cs[4], 4, 32'd0, 20'd0);
            send_req(2'd0, 8'h2b, cs[4], 4);
            expect_sw("R8", 2'd1, 8'h2b, 2'd0, cs[4], 4);
        end

        // preload and vector table
        mnt(1'b0, 10, 5,   32'h0000_1000, 20'd30);
        mnt(1'b0, 11, 200, 32'h0000_2000, 20'd33);
        mnt(1'b0, 12, 255, 32'h0000_3000, 20'd36);
        mnt(1'b0, 13, 1,   32'h0000_4000, 20'd39);
        for (int i = 0; i < 11; i++) begin
            vec_t v;
            v = VECS[i];
            send_req(v.op, 8'(8'h40 + i), int'(v.seed), int'(v.len));
            if (v.hit) begin
                expect_hit((v.len == 9'd255 || v.len == 9'd1) ? "R1" : "R3",
                           8'(8'h40 + i), v.ptr, 20'(int'(v.seed) * 3));
            end else begin
                expect_sw(v.kind == 2'd3 ? "R1" : (v.kind == 2'd2 ? "R6" : "R5"),
                          v.kind, 8'(8'h40 + i), v.op, int'(v.seed), int'(v.len));
            end
        end

        // R6 forwarded operations left the table alone
        send_req(2'd0, 8'h50, 11, 200);
        expect_hit("R6", 8'h50, 32'h0000_2000, 20'd33);

        // R1 overlong key rejected even for a read with a stored prefix
        send_req(2'd0, 8'h51, 12, 300);
        expect_sw("R1", 2'd3, 8'h51, 2'd0, 12, 300);

        // R9 / R10 latency and lookup-cycle blocking
        send_req(2'd0, 8'h52, 10, 5);
        chk("R9", "valid in lookup cycle", {63'd0, hit_valid | sw_valid}, 64'd0);
        chk("R10", "mnt_ready in lookup cycle", {63'd0, mnt_ready}, 64'd0);
        @(negedge clk);
        chk("R9", "hit_valid two edges after last", {63'd0, hit_valid}, 64'd1);
        chk("R10", "mnt_ready after lookup", {63'd0, mnt_ready}, 64'd1);
        expect_hit("R9", 8'h52, 32'h0000_1000, 20'd30);

        // R9 backpressure holds the response and blocks new requests
        sw_ready = 1'b0;
        send_req(2'd0, 8'h77, 15, 3);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9", "sw_valid held", {63'd0, sw_valid}, 64'd1);
        chk("R9", "sw_tag held", {56'd0, sw_tag}, 64'h77);
        chk("R9", "req_ready while busy", {63'd0, req_ready}, 64'd0);
        chk("R10", "single response", {63'd0, hit_valid}, 64'd0);
        sw_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "sw_valid after take", {63'd0, sw_valid}, 64'd0);
        chk("R9", "req_ready after take", {63'd0, req_ready}, 64'd1);

        // R9 order: back-to-back requests keep their tags in sequence
        send_req(2'd1, 8'h80, 20, 2);
        expect_sw("R9", 2'd2, 8'h80, 2'd1, 20, 2);
        send_req(2'd0, 8'h81, 13, 1);
        expect_hit("R9", 8'h81, 32'h0000_4000, 20'd39);

        finish_run();
    end
endmodule